// File: doc/BRIEF.md
# E1 Receive Serial Output Stage

This block is the clock-master output stage on the receive side of an E1 framer. An upstream framer hands over received time-slot bytes one at a time. Each byte has a strobe and three alignment markers: frame start, signaling-multiframe start and CRC-multiframe start. The block drives a serial clock, a serial data line and a frame pulse toward the system side. It runs from an internal clock at twice the bit rate, so one bit period is two internal cycles. The serial clock toggles every internal cycle, and either of its edges can be used to update data and pulse.

A two-entry byte buffer sits between the upstream byte strobe and the serializer. Bytes leave most significant bit first and back to back, with no gap between bytes. The frame pulse has three possible sources: held at zero, a marker of a chosen alignment boundary, or a one-cycle-delayed copy of an external common frame pulse. Polarity and the update edge of the pulse are selectable. When the pulse edge differs from the data edge, the pulse leads the data by half a bit.

The control flow is a three-state machine:
- `S_IDLE`: waits for a frame-start byte and discards any other byte.
- `S_ARM`: entered only when the two edge settings differ. The pulse has already been driven, and the first bit has not yet been loaded.
- `S_RUN`: continuous serialization.

The transitions are:
- IDLE→RUN, *start_same*: a frame-start byte is at the buffer head on a cycle that is both a data and a pulse edge.
- IDLE→ARM, *start_lead*: a frame-start byte is at the head on a pulse-only edge.
- ARM→RUN, *first_load*: the next data edge.

RUN has no exit except reset.

Top module: `e1rx_sys_out`

## Requirements
- R1: `ser_clk_o` is 0 while reset is held and inverts on every internal clock cycle after reset, so one bit period is two internal cycles.
- R2: After reset, `ser_data_o` is 1 and `underrun_o` is 0 until a byte with `in_sof_i`=1 reaches the buffer head. Bytes without the frame-start marker that arrive before it are discarded and never appear on `ser_data_o`.
- R3: Serialization starts with bit 7 of the frame-start byte. Each byte is output from bit 7 down to bit 0 and held for two internal cycles per bit. Consecutive buffered bytes follow with no gap.
- R4: With `cfg_dedge_i`=0, `ser_data_o` changes only on the internal edge that drives `ser_clk_o` to 1. With `cfg_dedge_i`=1, it changes only on the edge that drives `ser_clk_o` to 0.
- R5: `cfg_src_i`=2'b00 holds `fpulse_o` at 0 regardless of polarity. 2'b01 selects boundary indication. 2'b10 or 2'b11 makes `fpulse_o` equal to `ext_fp_i` as sampled one internal cycle earlier.
- R6: In boundary mode with `cfg_selen_i`=1, `cfg_sel_i` chooses the marked frames: 2'b00 every frame start, 2'b01 frames flagged by `in_smf_i`, 2'b10 frames flagged by `in_cmf_i`, 2'b11 frames flagged by both.
- R7: With `cfg_selen_i`=0, the pulse marks every frame start whatever `cfg_sel_i` holds.
- R8: With `cfg_inv_i`=0 the pulse is active high. With `cfg_inv_i`=1 it is active low, and `fpulse_o` rests at 1 between pulses in boundary mode.
- R9: An active pulse lasts exactly one bit period (two internal cycles), aligned with bit 7 of the frame-start byte.
- R10: `cfg_fedge_i` selects the pulse update edge with the same encoding as `cfg_dedge_i`. When the two settings differ, the pulse changes one internal cycle before the data bit it marks.
- R11: If the buffer is empty at a byte boundary while running, eight 1 bits are sent and `underrun_o` is 1 for that byte period. The next byte that arrives in the buffer is sent at the following byte boundary, and `underrun_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the serial bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | One-cycle strobe: byte and markers are valid |
| in_byte_i | input | 8 | Received time-slot byte |
| in_sof_i | input | 1 | Byte is time slot 0 of a frame |
| in_smf_i | input | 1 | Frame starts a signaling multiframe |
| in_cmf_i | input | 1 | Frame starts a CRC multiframe |
| cfg_src_i | input | 2 | Pulse source: 00 zero, 01 boundary, 1x external copy |
| cfg_sel_i | input | 2 | Boundary selector |
| cfg_selen_i | input | 1 | 0 forces basic-frame boundary |
| cfg_inv_i | input | 1 | 1 makes the pulse active low |
| cfg_dedge_i | input | 1 | Data update edge: 0 rising, 1 falling |
| cfg_fedge_i | input | 1 | Pulse update edge: 0 rising, 1 falling |
| ext_fp_i | input | 1 | External common frame pulse |
| ser_clk_o | output | 1 | Serial output clock |
| ser_data_o | output | 1 | Serial output data |
| fpulse_o | output | 1 | Frame pulse |
| underrun_o | output | 1 | High while a fill byte is being sent |

## Verification
The bench builds the block with its defaults: 8-bit slots and a two-entry buffer. The shallow buffer means an underrun follows as soon as feeding stops. Full 32-slot frames are sent in runs of six. The markers are arranged so that every frame, signaling starts, CRC starts and joint starts each give a different set of pulse positions. Every pairing of data and pulse edges is exercised against those sets.

// File: rtl/e1rx_pkg.sv
package e1rx_pkg;

    parameter int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              smf;
        logic              cmf;
    } slot_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_ARM  = 2'b01,
        S_RUN  = 2'b10
    } ser_state_e;

    typedef enum logic [1:0] {
        BND_FRAME = 2'b00,
        BND_SIG   = 2'b01,
        BND_CRC   = 2'b10,
        BND_BOTH  = 2'b11
    } bnd_e;

    localparam logic [1:0] SRC_ZERO = 2'b00;
    localparam logic [1:0] SRC_POS  = 2'b01;

endpackage

// File: rtl/e1rx_edge_gen.sv
module e1rx_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic dedge_i,
    input  logic fedge_i,
    output logic sclk_o,
    output logic upd_d_o,
    output logic upd_f_o
);

    logic ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    // ph_q low: the coming edge raises the serial clock
    always_comb begin
        sclk_o  = ph_q;
        upd_d_o = (ph_q == dedge_i);
        upd_f_o = (ph_q == fedge_i);
    end

endmodule

// File: rtl/e1rx_fifo.sv
module e1rx_fifo
    import e1rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  slot_t wdata_i,
    input  logic  pop_i,
    output logic  head_v_o,
    output slot_t head_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    slot_t            mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ok;

    always_comb begin
        wr_ok    = push_i && ((cnt_q != CNT_FULL) || pop_i);
        head_v_o = (cnt_q != '0);
        head_o   = mem[rp_q];
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
            if (pop_i) rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
            unique case ({wr_ok, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R11
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/e1rx_serializer.sv
module e1rx_serializer
    import e1rx_pkg::*;
#(
    parameter int BITS = BYTE_W
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd_d_i,
    input  logic  upd_f_i,
    input  logic  head_v_i,
    input  slot_t head_i,
    output logic  pop_o,
    output logic  at_bound_o,
    output logic  sdata_o,
    output logic  underrun_o
);

    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    ser_state_e       state_q, state_d;
    logic [BITS-1:0]  sr_q;
    logic [CNT_W-1:0] bcnt_q;
    logic             start_ok, load;

    always_comb begin
        start_ok   = upd_f_i && head_v_i && head_i.sof;
        at_bound_o = (state_q == S_IDLE) || ((state_q == S_RUN) && (bcnt_q == LAST));
        state_d    = state_q;
        load       = 1'b0;
        pop_o      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_ok) state_d = upd_d_i ? S_RUN : S_ARM;
                load  = upd_d_i && start_ok;
                pop_o = upd_d_i && head_v_i && (!head_i.sof || upd_f_i);
            end
            S_ARM: begin
                if (upd_d_i) state_d = S_RUN;
                load  = upd_d_i;
                pop_o = upd_d_i && head_v_i;
            end
            S_RUN: begin
                load  = upd_d_i && (bcnt_q == LAST);
                pop_o = load && head_v_i;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath / outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q       <= '1;
            bcnt_q     <= '0;
            sdata_o    <= 1'b1;
            underrun_o <= 1'b0;
        end else if (load) begin
            bcnt_q <= '0;
            if (head_v_i) begin
                sr_q       <= head_i.data;
                sdata_o    <= head_i.data[BITS-1];
                underrun_o <= 1'b0;
            end else begin
                sr_q       <= '1;
                sdata_o    <= 1'b1;
                underrun_o <= 1'b1;
            end
        end else if (upd_d_i && (state_q == S_RUN)) begin
            sr_q    <= {sr_q[BITS-2:0], 1'b1};
            sdata_o <= sr_q[BITS-2];
            bcnt_q  <= bcnt_q + 1'b1;
        end
    end

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_d_i |=> $stable(sdata_o));

    // R11
    fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> sdata_o);

endmodule

// File: rtl/e1rx_fp_gen.sv
module e1rx_fp_gen
    import e1rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_f_i,
    input  logic       at_bound_i,
    input  logic       head_v_i,
    input  logic       sof_i,
    input  logic       smf_i,
    input  logic       cmf_i,
    input  logic [1:0] src_i,
    input  logic [1:0] sel_i,
    input  logic       selen_i,
    input  logic       inv_i,
    input  logic       ext_i,
    output logic       fpulse_o
);

    bnd_e eff;
    logic match, hit;

    always_comb begin
        eff = selen_i ? bnd_e'(sel_i) : BND_FRAME;
        unique case (eff)
            BND_FRAME: match = 1'b1;
            BND_SIG:   match = smf_i;
            BND_CRC:   match = cmf_i;
            BND_BOTH:  match = smf_i & cmf_i;
            default:   match = 1'b0;
        endcase
        hit = at_bound_i && head_v_i && sof_i && match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                fpulse_o <= 1'b0;
        else if (src_i[1])         fpulse_o <= ext_i;
        else if (src_i == SRC_ZERO) fpulse_o <= 1'b0;
        else if (upd_f_i)          fpulse_o <= hit ^ inv_i;
    end

    // R10
    fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i == SRC_POS) && !upd_f_i) |=> $stable(fpulse_o));

endmodule

// File: rtl/e1rx_sys_out.sv
module e1rx_sys_out
    import e1rx_pkg::*;
#(
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_byte_i,
    input  logic              in_sof_i,
    input  logic              in_smf_i,
    input  logic              in_cmf_i,
    input  logic [1:0]        cfg_src_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic              cfg_selen_i,
    input  logic              cfg_inv_i,
    input  logic              cfg_dedge_i,
    input  logic              cfg_fedge_i,
    input  logic              ext_fp_i,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              fpulse_o,
    output logic              underrun_o
);

    slot_t wslot, head;
    logic  head_v, pop, upd_d, upd_f, at_bound;

    always_comb begin
        wslot.data = in_byte_i;
        wslot.sof  = in_sof_i;
        wslot.smf  = in_smf_i;
        wslot.cmf  = in_cmf_i;
    end

    e1rx_edge_gen u_edge (
        .clk(clk), .rst_n(rst_n),
        .dedge_i(cfg_dedge_i), .fedge_i(cfg_fedge_i),
        .sclk_o(ser_clk_o), .upd_d_o(upd_d), .upd_f_o(upd_f)
    );

    e1rx_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push_i(in_valid_i), .wdata_i(wslot), .pop_i(pop),
        .head_v_o(head_v), .head_o(head)
    );

    e1rx_serializer #(.BITS(BYTE_W)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .upd_d_i(upd_d), .upd_f_i(upd_f),
        .head_v_i(head_v), .head_i(head),
        .pop_o(pop), .at_bound_o(at_bound),
        .sdata_o(ser_data_o), .underrun_o(underrun_o)
    );

    e1rx_fp_gen u_fp (
        .clk(clk), .rst_n(rst_n),
        .upd_f_i(upd_f), .at_bound_i(at_bound), .head_v_i(head_v),
        .sof_i(head.sof), .smf_i(head.smf), .cmf_i(head.cmf),
        .src_i(cfg_src_i), .sel_i(cfg_sel_i), .selen_i(cfg_selen_i),
        .inv_i(cfg_inv_i), .ext_i(ext_fp_i), .fpulse_o(fpulse_o)
    );

endmodule

// File: tb/tb_e1rx_sys_out.sv
module tb_e1rx_sys_out;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_sof = 1'b0, in_smf = 1'b0, in_cmf = 1'b0;
    logic [1:0] src = 2'b01, sel = 2'b00;
    logic       selen = 1'b1, inv = 1'b0, dedge = 1'b0, fedge = 1'b0, ext = 1'b0;
    logic       sclk, sdat, fp, und;

    int n_chk = 0, n_fail = 0;
    int ecnt = 0, base = 0;
    bit logging = 1'b0;
    bit done = 1'b0;

    localparam int LOGN = 4096;
    logic s_clk [LOGN];
    logic s_dat [LOGN];
    logic s_fp  [LOGN];
    logic s_und [LOGN];
    logic s_ext [LOGN];

    e1rx_sys_out dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_byte_i(in_byte),
        .in_sof_i(in_sof), .in_smf_i(in_smf), .in_cmf_i(in_cmf),
        .cfg_src_i(src), .cfg_sel_i(sel), .cfg_selen_i(selen), .cfg_inv_i(inv),
        .cfg_dedge_i(dedge), .cfg_fedge_i(fedge), .ext_fp_i(ext),
        .ser_clk_o(sclk), .ser_data_o(sdat), .fpulse_o(fp), .underrun_o(und)
    );

    always #10 clk = ~clk;

    always @(posedge clk) ecnt <= ecnt + 1;

    always @(negedge clk) begin
        if (logging && (ecnt - base) < LOGN) begin
            s_clk[ecnt-base] = sclk;
            s_dat[ecnt-base] = sdat;
            s_fp[ecnt-base]  = fp;
            s_und[ecnt-base] = und;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    function automatic logic [7:0] byte_of(input int n);
        int slot = n % 32;
        int fr = n / 32;
        if (slot == 0) return 8'h1B;
        return 8'((((fr % 8) << 5) | slot) ^ 8'hA5);
    endfunction

    function automatic bit smf_of(input int fr); return (fr % 3) == 0; endfunction
    function automatic bit cmf_of(input int fr); return (fr % 2) == 0; endfunction

    function automatic bit exp_bit(input int k);
        logic [7:0] b = byte_of(k / 8);
        return b[7 - (k % 8)];
    endfunction

    function automatic bit exp_pulse(input int k, input logic [1:0] s, input logic en);
        int fr = k / 256;
        logic [1:0] e = en ? s : 2'b00;
        if ((k % 256) != 0) return 1'b0;
        case (e)
            2'b00: return 1'b1;
            2'b01: return smf_of(fr);
            2'b10: return cmf_of(fr);
            default: return smf_of(fr) && cmf_of(fr);
        endcase
    endfunction

    // One scenario: configure, reset, feed frames, then check the logged outputs.
    task automatic run_case(input string name, input string rq_fp,
                            input logic de, input logic fe, input logic [1:0] sr,
                            input logic [1:0] sl, input logic en, input logic iv,
                            input int nframes, input bit junk, input bit do_und);
        int nbytes = nframes * 32;
        int nbits  = nbytes * 8;
        int st     = junk ? 12 : 0;
        int pext   = st + 16 * (nbytes - 1) + 100;
        int total  = st + 16 * nbytes + 40 + (do_und ? 140 : 0);
        int off    = (de != fe) ? 1 : 0;
        int i0, bad, fa, fe_v;
        dedge = de; fedge = fe; src = sr; sel = sl; selen = en; inv = iv;
        ext = 1'b0; in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        base = ecnt;
        logging = 1'b1;
        for (int c = 0; c < total; c++) begin
            int n = -1;
            in_valid = 1'b0; in_sof = 1'b0; in_smf = 1'b0; in_cmf = 1'b0;
            if (junk && (c == 0 || c == 4)) begin
                in_valid = 1'b1; in_byte = 8'h00 + 8'(c);
            end
            if (c == st) n = 0;
            else if (c == st + 1 && nbytes > 1) n = 1;
            else if (c > st + 1 && ((c - st) % 16) == 0 && (c - st) / 16 + 1 < nbytes) n = (c - st) / 16 + 1;
            if (n >= 0) begin
                in_valid = 1'b1; in_byte = byte_of(n);
                in_sof = (n % 32) == 0;
                in_smf = in_sof && smf_of(n / 32);
                in_cmf = in_sof && cmf_of(n / 32);
            end
            if (do_und && c == pext) begin
                in_valid = 1'b1; in_byte = 8'h3C;
            end
            ext = ((c * 5) % 7) < 2;
            if (c < LOGN) s_ext[c] = ext;
            @(posedge clk);
            #2;
        end
        in_valid = 1'b0;
        @(negedge clk);
        logging = 1'b0;

        // R1: reset level and toggling
        bad = 0;
        for (int i = 1; i < total; i++) if (s_clk[i] == s_clk[i-1]) bad++;
        chk(s_clk[0] == 1'b0 && bad == 0, "R1", {name, " serial clock"}, bad, 0);

        // locate first bit of the frame-start byte (its bit 7 is 0)
        i0 = -1;
        for (int i = 1; i < total; i++)
            if (i0 < 0 && s_clk[i] == !de && s_dat[i] == 1'b0) i0 = i;
        chk(i0 > 0, "R3", {name, " stream start found"}, i0, 1);
        if (i0 <= 0) return;

        // R2: idle before start
        bad = 0;
        for (int i = 0; i < i0; i++) if (s_dat[i] !== 1'b1 || s_und[i] !== 1'b0) bad++;
        chk(bad == 0, "R2", {name, " idle before frame start"}, bad, 0);

        // R3: bit stream
        bad = 0; fa = 0; fe_v = 0;
        for (int k = 0; k < nbits; k++) begin
            bit e = exp_bit(k);
            if (s_dat[i0+2*k] !== e || s_dat[i0+2*k+1] !== e) begin
                if (bad == 0) begin fa = s_dat[i0+2*k]; fe_v = e; end
                bad++;
            end
        end
        chk(bad == 0, "R3", {name, " serial data msb first"}, fa, fe_v);

        // R4: data only changes on the selected clock edge
        bad = 0;
        for (int i = 1; i < total; i++)
            if (s_dat[i] != s_dat[i-1] && s_clk[i] != !de) bad++;
        chk(bad == 0, "R4", {name, " data edge"}, bad, 0);

        // frame pulse
        bad = 0; fa = 0; fe_v = 0;
        if (sr == 2'b01) begin
            for (int i = 2; i < i0 - off; i++)
                if (s_fp[i] !== iv) begin
                    if (bad == 0) begin fa = s_fp[i]; fe_v = iv; end
                    bad++;
                end
            chk(bad == 0, "R8", {name, " pulse rest level"}, fa, fe_v);
            bad = 0;
            for (int k = 0; k < nbits; k++) begin
                bit e = exp_pulse(k, sl, en) ^ iv;
                for (int h = 0; h < 2; h++)
                    if (s_fp[i0+2*k-off+h] !== e) begin
                        if (bad == 0) begin fa = s_fp[i0+2*k-off+h]; fe_v = e; end
                        bad++;
                    end
            end
            chk(bad == 0, rq_fp, {name, " pulse position/width (R9)"}, fa, fe_v);
        end else if (sr == 2'b00) begin
            for (int i = 0; i < total; i++) if (s_fp[i] !== 1'b0) bad++;
            chk(bad == 0, "R5", {name, " pulse held zero"}, bad, 0);
        end else begin
            for (int i = 1; i < total; i++) if (s_fp[i] !== s_ext[i-1]) bad++;
            chk(bad == 0, "R5", {name, " pulse copies external"}, bad, 0);
        end

        // R11: underrun fill and resume
        if (do_und) begin
            int ib = i0 + 2 * nbits;
            bad = 0;
            for (int h = 0; h < 16; h++) if (s_dat[ib+h] !== 1'b1 || s_und[ib+h] !== 1'b1) bad++;
            chk(bad == 0 && s_und[ib-1] === 1'b0, "R11", {name, " fill byte ones with flag"}, bad, 0);
            while (ib < pext + 2) ib += 16;
            bad = 0;
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v = 8'h3C;
                if (s_dat[ib+2*k] !== v[7-k] || s_und[ib+2*k] !== 1'b0) bad++;
            end
            chk(bad == 0 && s_und[ib-1] === 1'b1, "R11", {name, " resume after underrun"}, bad, 0);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        chk(sclk === 1'b0 && sdat === 1'b1 && und === 1'b0 && fp === 1'b0, "R2",
            "outputs in reset", {sclk, sdat, und, fp}, 4'b0100);
        run_case("basic", "R6", 1'b0, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 6, 1'b1, 1'b0);
        run_case("sig_lead", "R10", 1'b1, 1'b0, 2'b01, 2'b01, 1'b1, 1'b0, 6, 1'b0, 1'b0);
        run_case("crc_inv", "R10", 1'b0, 1'b1, 2'b01, 2'b10, 1'b1, 1'b1, 6, 1'b0, 1'b0);
        run_case("both", "R6", 1'b1, 1'b1, 2'b01, 2'b11, 1'b1, 1'b0, 6, 1'b0, 1'b0);
        run_case("override", "R7", 1'b0, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 6, 1'b0, 1'b0);
        run_case("zero_src", "R5", 1'b0, 1'b1, 2'b00, 2'b00, 1'b1, 1'b1, 2, 1'b0, 1'b0);
        run_case("copy_src", "R5", 1'b1, 1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        run_case("underrun", "R6", 1'b0, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1, 1'b0, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule